// File: doc/BRIEF.md
# DAC Load Strobe Advance Scheduler

This block produces the once-per-sample strobe that transfers a new word into the converter's input register. The strobe is placed a programmable number of internal clock cycles ahead of the next sample-period marker. That marker coincides with the frame sync announcing fresh ADC output. With no advance the strobe lands one serial clock period before the marker. Each unit of the 5-bit advance value pulls it a further eight internal clock cycles earlier, which shortens the group delay when conversion data flows from the ADC through a processor and back to the DAC.

The block learns the length of the sampling interval by counting cycles between consecutive markers. It learns the serial clock period by counting cycles between serial clock enable pulses. It then runs a down-counter to the expected next marker and fires when the remaining count equals the requested lead. The advance value is captured only while the converter section is powered down. If the requested lead is longer than the interval, the strobe is pulled back to the first cycle of the interval, so it never fires twice.

Top module: `dac_load_sched`

## Requirements
- R1: With advance 0, `load_o` is high in the cycle that lies S cycles before a marker cycle. S is the number of cycles between consecutive `sclk_en_i` pulses, and is 8 until two pulses have been seen.
- R2: With advance A, the lead is L = S + 8*A cycles. If the interval is P cycles long and starts with a marker in cycle t, `load_o` is high in cycle t + P - L.
- R3: All 32 values of the 5-bit advance field (0 to 31) give the timing of R2.
- R4: `load_o` is high for exactly one cycle per sampling interval, and never more than once between two markers.
- R5: The advance value is taken from `adv_i` at every clock edge where `powered_i` is 0, and is used from the following cycle. Changes to `adv_i` while `powered_i` is 1 have no effect on strobe timing.
- R6: `load_o` is low during reset and until two markers have been seen. The first strobe falls in the interval that begins with the second marker.
- R7: If L > P - 1, the strobe fires in the first cycle after the marker (cycle t + 1).
- R8: The interval length P used for the countdown is the measured length of the most recently completed interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal master clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk_en_i | input | 1 | One-cycle pulse per serial clock period |
| period_mark_i | input | 1 | One-cycle pulse at each output frame sync; starts a sampling interval |
| adv_i | input | ADV_W (5) | Requested advance in steps of 8 clock cycles |
| powered_i | input | 1 | Converter section powered; 0 lets the advance value be captured |
| load_o | output | 1 | One-cycle converter load strobe |

## Verification
Take a marker in cycle t. The strobe is due in cycle t + P - min(S + 8*A, P - 1). A new advance written with `powered_i` low takes effect one cycle later. The bench drives every input at the falling edge and compares `load_o` in that same cycle against the arithmetic expectation. It does this for every cycle of each run, so that both early and late strobes are caught. Sweeps cover all 32 advance values, two interval lengths (one of them short enough to force clamping), and four serial clock periods. Some runs write a different advance while powered and others re-latch one mid-run.

// File: rtl/dals_pkg.sv
`timescale 1ns/1ps
package dals_pkg;
  localparam int unsigned SPAN_W = 16;
  typedef logic [SPAN_W-1:0] span_t;

  function automatic span_t sat_inc(input span_t v);
    return (v == '1) ? v : v + span_t'(1);
  endfunction
endpackage

// File: rtl/dals_period_meter.sv
`timescale 1ns/1ps
module dals_period_meter
  import dals_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  mark_i,
  output span_t elapsed_o,
  output span_t period_o,
  output logic  armed_o
);
  span_t run_q, run_d, per_q, per_d;
  logic  seen_q, seen_d, armed_q, armed_d;

  always_comb begin
    run_d   = mark_i ? span_t'(1) : sat_inc(run_q);
    per_d   = per_q;
    seen_d  = seen_q | mark_i;
    armed_d = armed_q;
    if (mark_i && seen_q) begin
      per_d   = run_q;
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      per_q   <= '0;
      seen_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      per_q   <= per_d;
      seen_q  <= seen_d;
      armed_q <= armed_d;
    end
  end

  assign elapsed_o = run_q;
  assign period_o  = per_q;
  assign armed_o   = armed_q;
endmodule

// File: rtl/dals_sclk_meter.sv
`timescale 1ns/1ps
module dals_sclk_meter
  import dals_pkg::*;
#(
  parameter int unsigned DEF_SCLK = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  output span_t sclk_per_o
);
  span_t run_q, run_d, gap_q, gap_d;
  logic  seen_q, seen_d, ok_q, ok_d;

  always_comb begin
    run_d  = tick_i ? span_t'(1) : sat_inc(run_q);
    gap_d  = gap_q;
    seen_d = seen_q | tick_i;
    ok_d   = ok_q;
    if (tick_i && seen_q) begin
      gap_d = run_q;
      ok_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      gap_q  <= '0;
      seen_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      run_q  <= run_d;
      gap_q  <= gap_d;
      seen_q <= seen_d;
      ok_q   <= ok_d;
    end
  end

  assign sclk_per_o = ok_q ? gap_q : span_t'(DEF_SCLK);
endmodule

// File: rtl/dals_adv_hold.sv
`timescale 1ns/1ps
module dals_adv_hold #(
  parameter int unsigned ADV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ADV_W-1:0] adv_i,
  input  logic             powered_i,
  output logic [ADV_W-1:0] adv_o
);
  logic [ADV_W-1:0] adv_q, adv_d;
  logic             cap_en;

  assign cap_en = ~powered_i;

  always_comb begin
    adv_d = adv_q;
    if (cap_en) adv_d = adv_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) adv_q <= '0;
    else         adv_q <= adv_d;
  end

  assign adv_o = adv_q;
endmodule

// File: rtl/dals_strobe_gen.sv
`timescale 1ns/1ps
module dals_strobe_gen
  import dals_pkg::*;
#(
  parameter int unsigned ADV_W     = 5,
  parameter int unsigned STEP_LOG2 = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mark_i,
  input  span_t            elapsed_i,
  input  span_t            period_i,
  input  logic             armed_i,
  input  span_t            sclk_per_i,
  input  logic [ADV_W-1:0] adv_i,
  output logic             load_o
);
  localparam int unsigned LW = SPAN_W + 1;

  span_t         cnt_q, cnt_d, lim, lead_eff;
  logic [LW-1:0] lead_w, adv_w;
  logic          fired_q, fired_d, fire;

  always_comb begin
    adv_w    = {{(LW-ADV_W){1'b0}}, adv_i};
    lead_w   = {1'b0, sclk_per_i} + (adv_w << STEP_LOG2);
    lim      = period_i - span_t'(1);
    lead_eff = (lead_w > {1'b0, lim}) ? lim : lead_w[SPAN_W-1:0];
    fire     = armed_i & ~fired_q & (cnt_q == lead_eff);
  end

  always_comb begin
    cnt_d   = cnt_q;
    fired_d = fired_q | fire;
    if (mark_i) begin
      cnt_d   = elapsed_i - span_t'(1);
      fired_d = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - span_t'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fired_q <= fired_d;
    end
  end

  assign load_o = fire;
endmodule

// File: rtl/dac_load_sched.sv
`timescale 1ns/1ps
module dac_load_sched
  import dals_pkg::*;
#(
  parameter int unsigned ADV_W     = 5,
  parameter int unsigned STEP_LOG2 = 3,
  parameter int unsigned DEF_SCLK  = 8,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_en_i,
  input  logic             period_mark_i,
  input  logic [ADV_W-1:0] adv_i,
  input  logic             powered_i,
  output logic             load_o
);
  logic [SYNC_LEN-1:0] sync_q;
  logic                rst_sync_n;
  span_t               elapsed, period, sclk_per;
  logic                armed;
  logic [ADV_W-1:0]    adv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_sync_n = sync_q[SYNC_LEN-1];

  dals_period_meter u_period (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .mark_i(period_mark_i),
    .elapsed_o(elapsed), .period_o(period), .armed_o(armed)
  );

  dals_sclk_meter #(.DEF_SCLK(DEF_SCLK)) u_sclk (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .tick_i(sclk_en_i),
    .sclk_per_o(sclk_per)
  );

  dals_adv_hold #(.ADV_W(ADV_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .adv_i(adv_i),
    .powered_i(powered_i), .adv_o(adv_q)
  );

  dals_strobe_gen #(.ADV_W(ADV_W), .STEP_LOG2(STEP_LOG2)) u_gen (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .mark_i(period_mark_i),
    .elapsed_i(elapsed), .period_i(period), .armed_i(armed),
    .sclk_per_i(sclk_per), .adv_i(adv_q), .load_o(load_o)
  );
endmodule

// File: rtl/dals_chk.sv
`timescale 1ns/1ps
module dals_chk #(
  parameter int unsigned ADV_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             period_mark_i,
  input logic             powered_i,
  input logic [ADV_W-1:0] adv_i,
  input logic [ADV_W-1:0] adv_q_i,
  input logic             load_o
);
  logic [1:0] marks_q, since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      marks_q <= '0;
      since_q <= '0;
    end else begin
      if (period_mark_i && marks_q != 2'd2) marks_q <= marks_q + 2'd1;
      if (period_mark_i)                    since_q <= '0;
      else if (load_o && since_q != 2'd3)   since_q <= since_q + 2'd1;
    end
  end

  assert_single_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> since_q == 2'd0);

  assert_no_early_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> marks_q == 2'd2);

  assert_adv_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    powered_i |=> $stable(adv_q_i));

  assert_adv_captured_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !powered_i |=> adv_q_i == $past(adv_i));
endmodule

bind dac_load_sched dals_chk #(.ADV_W(ADV_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_sync_n), .period_mark_i(period_mark_i),
  .powered_i(powered_i), .adv_i(adv_i), .adv_q_i(adv_q), .load_o(load_o)
);

// File: tb/dac_load_sched_tb_top.sv
`timescale 1ns/1ps
module dac_load_sched_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk_en = 1'b0;
  logic       mark = 1'b0;
  logic [4:0] adv = '0;
  logic       powered = 1'b0;
  logic       load;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  dac_load_sched dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_en_i(sclk_en),
    .period_mark_i(mark), .adv_i(adv), .powered_i(powered), .load_o(load)
  );

  task automatic check(input logic act, input logic exp, input string tag, input int n);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s cycle %0d: load=%0b expected %0b", tag, n, act, exp);
    end
  endtask

  task automatic do_reset(input int a0);
    @(negedge clk);
    rst_n = 1'b0; mark = 1'b0; sclk_en = 1'b0; powered = 1'b0; adv = 5'(a0);
    repeat (3) @(negedge clk);
    check(load, 1'b0, "R6 reset", -1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // One run: marker every P cycles, serial tick every S cycles, advance a0
  // latched before power-up; a different value is written while powered (R5).
  task automatic run_scn(input int P, input int S, input int a0,
                         input bit relatch, input int a_new);
    int  a_lat = a0;
    bit  fired = 1'b0;
    int  n0 = 3 * P + 2;
    do_reset(a0);
    for (int n = 0; n < 5 * P; n++) begin
      int    lead, le;
      logic  exp;
      string tag;
      @(negedge clk);
      mark    = (n % P == 0);
      sclk_en = (n % S == 0);
      if (n == 2) powered = 1'b1;
      if (n == P + 3) adv = 5'(a0) ^ 5'h1f;
      if (relatch && n == n0) begin powered = 1'b0; adv = 5'(a_new); end
      if (relatch && n == n0 + 1) a_lat = a_new;
      if (relatch && n == n0 + 2) begin powered = 1'b1; adv = 5'(a_new) ^ 5'h15; end
      lead = S + 8 * a_lat;
      le   = (lead > P - 1) ? P - 1 : lead;
      if (n % P == 0) fired = 1'b0;
      exp = !fired && n > P && (n % P) == P - le;
      if (exp) fired = 1'b1;
      if (n <= P)                     tag = "R6 not armed";
      else if (relatch && n > n0)     tag = "R5 relatched advance";
      else if ((n % P) == P - le) begin
        if (le < lead)                tag = "R7 clamped lead";
        else if (a_lat == 0)          tag = "R1 default lead";
        else                          tag = "R2 advanced lead";
      end else                        tag = "R4 single strobe";
      check(load, exp, tag, n);
    end
  endtask

  initial begin
    // Short interval: large advances exceed it and clamp (R7); every advance code (R3)
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 32; a++)
        run_scn(40, (s == 0) ? 2 : 4, a, 1'b0, 0);
    // Long interval: full range unclamped, with re-latch (R3, R5, R8)
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 32; a++)
        run_scn(300, (s == 0) ? 1 : 8, a, 1'b1, (a + 7) % 32);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL R4 watchdog: run still active=1 expected 0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule